// File: doc/BRIEF.md
# Serial-Memory Register Initialization Loader

After a start pulse, this block copies a configuration image from a byte-addressed serial memory into the registers of a target device. The image is a list of fixed 4-byte records. Each record holds a 16-bit register address and then a 16-bit data value, both with the most significant byte first. The loader fetches every byte through a request/acknowledge byte-read port that serves one random read per handshake. It puts the four bytes together and then writes one register on a parallel bus. A select line frames each write.

The records form three sections that sit one after another in the memory. The first has 29 records, the second has 18 and the third has 19, so a full load is 66 records. Record r starts at memory byte 4·r. When the last record has been written, the loader raises done and keeps it high until the next start. If the byte reader reports an error, the loader stops at once. It then raises done together with an error flag and shows the index of the record that failed.

Top module: `cfg_loader`

## Requirements
- R1: While reset is active and afterwards until a start, rd_req_o, reg_sel_o, reg_wr_o, busy_o, done_o and err_o are all 0.
- R2: Bytes are requested one at a time, each at address 4·r+k, for records r=0,1,2,… and byte k=0..3 within each record. rd_req_o and rd_addr_o stay steady until rd_ack_i. rd_req_o is never high while reg_sel_o is high.
- R3: reg_addr_o is {byte0, byte1} of the record and reg_data_o is {byte2, byte3}. Byte 0 is the most significant byte of each value.
- R4: reg_sel_o goes high one cycle before reg_wr_o rises and stays high for one cycle after reg_wr_o falls. reg_addr_o and reg_data_o do not change while reg_sel_o is high.
- R5: Each reg_wr_o pulse lasts exactly WR_CYCLES clock cycles (3 by default).
- R6: A full load writes exactly one register per record, in record order: 29 + 18 + 19 = 66 writes, covering records 0 to 65 across the section boundaries at 29 and 47.
- R7: After the last write, done_o is 1 and busy_o is 0, and they stay that way until the next start. A start pulse while busy_o is 1 has no effect.
- R8: If a byte read returns rd_err_i=1, no more reads or writes follow. done_o and err_o become 1, and fail_idx_o holds the index of the record that was being fetched. That record is not written.
- R9: A start pulse while done_o is 1 begins a new load from record 0 and clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a load |
| rd_req_o | output | 1 | Byte-read request, held until acknowledged |
| rd_addr_o | output | 16 | Memory byte address of the request |
| rd_ack_i | input | 1 | One-cycle response strobe |
| rd_data_i | input | 8 | Byte returned with rd_ack_i |
| rd_err_i | input | 1 | Read failed, valid with rd_ack_i |
| reg_sel_o | output | 1 | Target select framing a write |
| reg_wr_o | output | 1 | Register write strobe |
| reg_addr_o | output | 16 | Register address |
| reg_data_o | output | 16 | Register data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished (with or without error) |
| err_o | output | 1 | Load stopped on a read error |
| fail_idx_o | output | 7 | Index of the failing record when err_o is 1 |

## Verification
The bound checker watches the write framing on every cycle: select before and after the strobe, address and data steady under select, and the exact strobe width. It also checks that reads and writes never overlap, that a pending request holds its address, and that err implies done and done implies idle. Only the bench's scenarios can show the actual read address order, the big-endian assembly of each record, the total of 66 writes across the section edges, the failing record index after an injected error, the restart after done, and that a start pulse in mid-load has no effect.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int SEC_N    = 3;
  localparam int SEC_LEN0 = 29;
  localparam int SEC_LEN1 = 18;
  localparam int SEC_LEN2 = 19;
  localparam int REC_TOT  = SEC_LEN0 + SEC_LEN1 + SEC_LEN2;
  localparam int REC_W    = $clog2(REC_TOT);
  localparam int SEC_W    = $clog2(SEC_N);
  localparam int REC_BYTES = 4;
  localparam int BSEL_W   = $clog2(REC_BYTES);

  typedef enum logic [2:0] {
    LD_IDLE, LD_FETCH, LD_SETUP, LD_STROBE, LD_HOLD, LD_DONE
  } ld_state_t;

  function automatic logic [REC_W-1:0] sec_len(input logic [SEC_W-1:0] s);
    case (s)
      SEC_W'(0): sec_len = REC_W'(SEC_LEN0);
      SEC_W'(1): sec_len = REC_W'(SEC_LEN1);
      default:   sec_len = REC_W'(SEC_LEN2);
    endcase
  endfunction
endpackage

// File: rtl/cfg_rec_asm.sv
module cfg_rec_asm
  import cfg_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shift_en,
  input  logic [7:0]  byte_in,
  output logic [15:0] addr_out,
  output logic [15:0] data_out
);
  localparam int WORD_W = REC_BYTES * 8;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[WORD_W-9:0], byte_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign addr_out = word_q[WORD_W-1 -: 16];
  assign data_out = word_q[15:0];
endmodule

// File: rtl/cfg_rec_walk.sv
module cfg_rec_walk
  import cfg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_adv,
  input  logic              rec_adv,
  output logic [REC_W-1:0]  rec_idx,
  output logic [BSEL_W-1:0] byte_idx,
  output logic              last_byte,
  output logic              last_rec
);
  logic [REC_W-1:0]  rec_q, rec_d, left_q, left_d;
  logic [BSEL_W-1:0] byte_q, byte_d;
  logic [SEC_W-1:0]  sec_q, sec_d;

  always_comb begin
    rec_d  = rec_q;
    byte_d = byte_q;
    sec_d  = sec_q;
    left_d = left_q;
    if (clr) begin
      rec_d  = '0;
      byte_d = '0;
      sec_d  = '0;
      left_d = sec_len('0);
    end else if (rec_adv) begin
      rec_d  = rec_q + 1'b1;
      byte_d = '0;
      if (left_q == REC_W'(1)) begin
        sec_d  = sec_q + 1'b1;
        left_d = sec_len(sec_q + 1'b1);
      end else begin
        left_d = left_q - 1'b1;
      end
    end else if (byte_adv) begin
      byte_d = byte_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q  <= '0;
      byte_q <= '0;
      sec_q  <= '0;
      left_q <= '0;
    end else begin
      rec_q  <= rec_d;
      byte_q <= byte_d;
      sec_q  <= sec_d;
      left_q <= left_d;
    end
  end

  assign rec_idx   = rec_q;
  assign byte_idx  = byte_q;
  assign last_byte = (byte_q == BSEL_W'(REC_BYTES - 1));
  assign last_rec  = (sec_q == SEC_W'(SEC_N - 1)) && (left_q == REC_W'(1));
endmodule

// File: rtl/cfg_strobe_timer.sv
module cfg_strobe_timer #(
  parameter int WR_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic last
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(WR_CYCLES - 1));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int WR_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        rd_req_o,
  output logic [15:0] rd_addr_o,
  input  logic        rd_ack_i,
  input  logic [7:0]  rd_data_i,
  input  logic        rd_err_i,
  output logic        reg_sel_o,
  output logic        reg_wr_o,
  output logic [15:0] reg_addr_o,
  output logic [15:0] reg_data_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [6:0]  fail_idx_o
);
  localparam int PAD_W = 16 - REC_W - BSEL_W;

  ld_state_t         st_q, st_d;
  logic              err_q, err_d;
  logic              clr, byte_adv, rec_adv, shift_en;
  logic              t_load, t_run, t_last;
  logic [REC_W-1:0]  rec_idx;
  logic [BSEL_W-1:0] byte_idx;
  logic              last_byte, last_rec;

  cfg_rec_walk u_walk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .byte_adv(byte_adv), .rec_adv(rec_adv),
    .rec_idx(rec_idx), .byte_idx(byte_idx), .last_byte(last_byte), .last_rec(last_rec)
  );

  cfg_rec_asm u_asm (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .byte_in(rd_data_i),
    .addr_out(reg_addr_o), .data_out(reg_data_o)
  );

  cfg_strobe_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .run(t_run), .last(t_last)
  );

  always_comb begin
    st_d     = st_q;
    err_d    = err_q;
    clr      = 1'b0;
    byte_adv = 1'b0;
    rec_adv  = 1'b0;
    shift_en = 1'b0;
    t_load   = 1'b0;
    t_run    = 1'b0;
    case (st_q)
      LD_IDLE, LD_DONE: begin
        if (start_i) begin
          clr   = 1'b1;
          err_d = 1'b0;
          st_d  = LD_FETCH;
        end
      end
      LD_FETCH: begin
        if (rd_ack_i) begin
          if (rd_err_i) begin
            err_d = 1'b1;
            st_d  = LD_DONE;
          end else begin
            shift_en = 1'b1;
            if (last_byte) st_d = LD_SETUP;
            else           byte_adv = 1'b1;
          end
        end
      end
      LD_SETUP: begin
        t_load = 1'b1;
        st_d   = LD_STROBE;
      end
      LD_STROBE: begin
        t_run = 1'b1;
        if (t_last) st_d = LD_HOLD;
      end
      LD_HOLD: begin
        if (last_rec) begin
          st_d = LD_DONE;
        end else begin
          rec_adv = 1'b1;
          st_d    = LD_FETCH;
        end
      end
      default: st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LD_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign rd_req_o   = (st_q == LD_FETCH);
  assign rd_addr_o  = {{PAD_W{1'b0}}, rec_idx, byte_idx};
  assign reg_sel_o  = (st_q == LD_SETUP) || (st_q == LD_STROBE) || (st_q == LD_HOLD);
  assign reg_wr_o   = (st_q == LD_STROBE);
  assign busy_o     = (st_q != LD_IDLE) && (st_q != LD_DONE);
  assign done_o     = (st_q == LD_DONE);
  assign err_o      = err_q;
  assign fail_idx_o = err_q ? 7'(rec_idx) : 7'd0;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int WR_CYCLES = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req_o,
  input logic        rd_ack_i,
  input logic [15:0] rd_addr_o,
  input logic        reg_sel_o,
  input logic        reg_wr_o,
  input logic [15:0] reg_addr_o,
  input logic [15:0] reg_data_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  logic [15:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wcnt_q <= '0;
    else if (reg_wr_o) wcnt_q <= wcnt_q + 16'd1;
    else               wcnt_q <= '0;
  end

  a_r4_wr_in_sel: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> reg_sel_o);
  a_r4_sel_before: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr_o) |-> $past(reg_sel_o));
  a_r4_sel_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_wr_o) |-> reg_sel_o);
  a_r4_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_o && $past(reg_sel_o)) |-> ($stable(reg_addr_o) && $stable(reg_data_o)));
  a_r5_wr_max: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (wcnt_q < 16'(WR_CYCLES)));
  a_r5_wr_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_wr_o) |-> (wcnt_q == 16'(WR_CYCLES)));
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !reg_sel_o);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && $past(rd_req_o) && !$past(rd_ack_i)) |-> $stable(rd_addr_o));
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !rd_req_o && !reg_sel_o));
  a_r8_err_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
endmodule

bind cfg_loader cfg_loader_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
  .rd_addr_o(rd_addr_o), .reg_sel_o(reg_sel_o), .reg_wr_o(reg_wr_o),
  .reg_addr_o(reg_addr_o), .reg_data_o(reg_data_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 3;
  localparam int LAT = 2;
  localparam int NREC = 66;
  localparam int NPICK = 8;
  localparam int PICK [NPICK] = '{0, 1, 28, 29, 46, 47, 64, 65};

  logic clk, rst_n, start_i;
  logic rd_req_o, rd_ack_i, rd_err_i;
  logic [15:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic reg_sel_o, reg_wr_o, busy_o, done_o, err_o;
  logic [15:0] reg_addr_o, reg_data_o;
  logic [6:0] fail_idx_o;

  cfg_loader #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .rd_err_i(rd_err_i),
    .reg_sel_o(reg_sel_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
    .reg_data_o(reg_data_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .fail_idx_o(fail_idx_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int err_addr = -1;

  function automatic logic [7:0] mem_byte(input int a);
    logic [15:0] x;
    x = 16'(a);
    return 8'(x * 16'd37 + 16'd11) ^ x[15:8];
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  int lat_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack_i <= 1'b0; rd_err_i <= 1'b0; rd_data_i <= 8'h00; lat_cnt <= 0;
    end else if (rd_ack_i) begin
      rd_ack_i <= 1'b0; rd_err_i <= 1'b0; lat_cnt <= 0;
    end else if (rd_req_o) begin
      if (lat_cnt == LAT) begin
        rd_ack_i  <= 1'b1;
        rd_data_i <= mem_byte(int'(rd_addr_o));
        rd_err_i  <= (int'(rd_addr_o) == err_addr);
      end else lat_cnt <= lat_cnt + 1;
    end else lat_cnt <= 0;
  end

  // monitor, sampled on the falling edge
  int exp_req, seq_bad, seq_act, seq_exp;
  int n_wr, wr_len, len_bad, frame_bad;
  logic [15:0] cap_addr [NREC];
  logic [15:0] cap_data [NREC];
  logic prev_wr, prev_sel;
  logic [15:0] prev_addr;
  bit mon_clr;

  always @(negedge clk) begin
    if (mon_clr) begin
      exp_req = 0; seq_bad = 0; n_wr = 0; wr_len = 0; len_bad = 0; frame_bad = 0;
      prev_wr = 0; prev_sel = 0; prev_addr = 0;
    end else begin
      if (rd_req_o && rd_ack_i) begin
        if (int'(rd_addr_o) != exp_req && seq_bad == 0) begin
          seq_act = int'(rd_addr_o); seq_exp = exp_req;
        end
        if (int'(rd_addr_o) != exp_req) seq_bad++;
        exp_req++;
      end
      if (reg_wr_o) begin
        wr_len++;
        if (!prev_wr) begin
          if (!prev_sel || prev_addr != reg_addr_o) frame_bad++;
          if (n_wr < NREC) begin
            cap_addr[n_wr] = reg_addr_o; cap_data[n_wr] = reg_data_o;
          end
          n_wr++;
        end
      end else begin
        if (prev_wr) begin
          if (wr_len != WRC) len_bad++;
          if (!reg_sel_o) frame_bad++;
        end
        wr_len = 0;
      end
      prev_wr = reg_wr_o; prev_sel = reg_sel_o; prev_addr = reg_addr_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic clear_mon();
    mon_clr = 1;
    @(negedge clk);
    mon_clr = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_o && t < 20000) begin @(negedge clk); t++; end
    check("R7 done reached", done_o, 1);
  endtask

  initial begin
    int t;
    for (t = 0; t < 190000; t++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    start_i = 1'b0; rst_n = 1'b0; mon_clr = 1;
    repeat (3) @(negedge clk);
    check("R1 req in reset", rd_req_o, 0);
    check("R1 busy in reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle sel/wr", {reg_sel_o, reg_wr_o}, 0);
    check("R1 idle done/err", {done_o, err_o}, 0);
    check("R1 idle req", rd_req_o, 0);

    // full load, with a stray start mid-run
    mon_clr = 0;
    pulse_start();
    check("R7 busy after start", busy_o, 1);
    while (n_wr < 10) @(negedge clk);
    pulse_start();
    wait_done();
    check("R7 busy low at done", busy_o, 0);
    check("R6 write count", n_wr, NREC);
    check("R2 read order mismatches", seq_bad, 0);
    if (seq_bad != 0) check("R2 first bad address", seq_act, seq_exp);
    check("R2 read count", exp_req, 4 * NREC);
    check("R5 strobe width errors", len_bad, 0);
    check("R4 framing errors", frame_bad, 0);
    check("R8 no error on clean run", err_o, 0);
    for (int i = 0; i < NPICK; i++) begin
      int r = PICK[i];
      check($sformatf("R3 addr rec %0d", r), cap_addr[r],
            {mem_byte(4*r), mem_byte(4*r+1)});
      check($sformatf("R3 data rec %0d", r), cap_data[r],
            {mem_byte(4*r+2), mem_byte(4*r+3)});
    end
    repeat (20) @(negedge clk);
    check("R7 done held", {done_o, busy_o, rd_req_o}, 3'b100);

    // error injection on record 40, byte 2
    err_addr = 4 * 40 + 2;
    clear_mon();
    pulse_start();
    check("R9 restart busy", {busy_o, done_o}, 2'b10);
    wait_done();
    check("R8 err flag", err_o, 1);
    check("R8 fail index", fail_idx_o, 40);
    check("R8 writes before error", n_wr, 40);
    check("R8 reads before error", exp_req, 4 * 40 + 3);
    repeat (10) @(negedge clk);
    check("R8 no read after error", exp_req, 4 * 40 + 3);
    check("R8 no write after error", n_wr, 40);

    // restart clears error
    err_addr = -1;
    clear_mon();
    pulse_start();
    check("R9 err cleared", err_o, 0);
    wait_done();
    check("R9 full reload count", n_wr, NREC);
    check("R9 first record again", cap_addr[0], {mem_byte(0), mem_byte(1)});
    check("R9 order on reload", seq_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule